// File: doc/BRIEF.md
# Link Rate-Change Recovery Sequencer

This block is a control state machine that sits beside a link-training engine and steers it through bring-up, speed promotion and the low-power round trip. The receiver can hang during a change of link rate. The block therefore always trains the link at the low rate first. It promotes to the high rate only after the link is active. After each rate change it waits a fixed dwell, then checks whether training is stuck. If it is stuck, the block resets the receiver.

At bring-up the sequencer holds training off with high-rate support cleared for one cycle. It then releases training and waits for the active state code. If the link partner can run fast, it grants high-rate support and issues a one-cycle speed-up request. A dwell counter then runs for `CHECK_CYCLES` cycles. The default is sized for a 2 ms wait, which sits well inside the 24 ms training timeout and far above the receiver lock time. At the last cycle of the dwell the block samples the training code and receive-valid. It fires a receiver reset of `RST_CYCLES` cycles only if training sits in receiver-lock recovery with receive-valid low.

A low-power entry request drops the link to the slow rate, so it runs the same dwell and check. A wake request clears high-rate support and leaves training enabled. The sequence then waits for the active state again and repeats the promotion.

Top module: `rate_change_guard`

## Requirements
- R1: After a synchronous active-low reset, all outputs (train_en_o, fast_allow_o, fast_req_o, low_power_o, rx_rst_o) are 0, and the block waits in idle for bringup_req_i.
- R2: In the cycle after bringup_req_i is sampled in idle, training stays disabled with fast_allow_o low. In the next cycle train_en_o rises while fast_allow_o is still 0.
- R3: While training is enabled and train_code_i differs from ACTIVE_CODE (default 6'h11), fast_req_o stays 0. When ACTIVE_CODE is sampled with partner_fast_i=1, fast_allow_o is 1 and fast_req_o is high for exactly one cycle starting the next cycle. With partner_fast_i=0, no request is made and fast_allow_o stays 0.
- R4: The stuck check samples the inputs at the end of the last of CHECK_CYCLES dwell cycles. For a promotion, the dwell starts the cycle after the fast_req_o cycle. For a low-power entry, it starts in the first cycle low_power_o is 1.
- R5: The check counts as stuck only when train_code_i equals RLOCK_CODE (default 6'h0D) and rx_valid_i is 0 at the sampling edge. Any other combination at that edge, including one that was stuck earlier in the dwell, yields no reset.
- R6: A stuck check raises rx_rst_o in the cycle right after the sampling edge. It holds rx_rst_o for exactly RST_CYCLES cycles, only once per check.
- R7: A sleep_req_i sampled while running at the active state sets low_power_o in the next cycle. It runs the dwell and stuck check, and low_power_o stays 1 afterwards until a wake.
- R8: A wake_req_i sampled while in low power gives, in the next cycle, low_power_o=0, fast_allow_o=0 and train_en_o=1. After ACTIVE_CODE is seen again, the promotion of R3 repeats.
- R9: sleep_req_i outside the running state, wake_req_i outside low power and bringup_req_i outside idle have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| train_code_i | input | CODE_W | Current state code of the link-training engine |
| rx_valid_i | input | 1 | Receiver reports valid data (lock) |
| partner_fast_i | input | 1 | Link partner supports the high rate |
| bringup_req_i | input | 1 | Driver request to start the cold bring-up |
| sleep_req_i | input | 1 | Driver request to enter the low-power state |
| wake_req_i | input | 1 | Driver request to leave the low-power state |
| train_en_o | output | 1 | Link training enabled |
| fast_allow_o | output | 1 | High-rate support advertised to the training engine |
| fast_req_o | output | 1 | One-cycle request to move to the high rate |
| low_power_o | output | 1 | Request to the training engine to enter or hold low power |
| rx_rst_o | output | 1 | Receiver reset pulse |

## Verification
The hard case to reach is a stuck condition that changes within the dwell, since the block samples only at one edge. The bench drives the training code and receive-valid cycle by cycle from the observed request. It uses one pattern before the sampling edge and another at that edge, including stuck-then-recovered and clean-then-stuck. It then compares rx_rst_o with the expected window on every cycle. It reaches the check from both directions by looping through promotion, low-power entry and wake with a short dwell parameter.

// File: rtl/rcg_pkg.sv
// Package: shared state encoding for the rate-change guard.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package rcg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,  // waiting for a bring-up request
        ST_QUIESCE  = 4'd1,  // training off, fast support off
        ST_TRAIN    = 4'd2,  // training released, waiting for active state
        ST_PROMOTE  = 4'd3,  // one-cycle high-rate request
        ST_DWELL_UP = 4'd4,  // timed wait after promotion
        ST_RUN      = 4'd5,  // link active
        ST_DWELL_DN = 4'd6,  // timed wait after low-power entry
        ST_SLEEP    = 4'd7,  // low power held
        ST_WAKE     = 4'd8   // wake: drop fast support, keep training on
    } seq_state_t;

    // True for the two states in which the dwell timer runs.
    function automatic logic is_dwell(input seq_state_t s);
        return (s == ST_DWELL_UP) || (s == ST_DWELL_DN);
    endfunction

endpackage

// File: rtl/rcg_dwell_timer.sv
// Module: rcg_dwell_timer
// Counts consecutive cycles while run_i is high and flags the last one.
// Assumes: run_i drops in the cycle after expire_o (the owner leaves the
// dwell state), and CHECK_CYCLES >= 2.
module rcg_dwell_timer #(
    parameter int CHECK_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);
    localparam int CNT_W = (CHECK_CYCLES > 2) ? $clog2(CHECK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHECK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Last dwell cycle is reached when the count hits CHECK_CYCLES-1.
    assign expire_o = run_i && (cnt_q == LAST);

    // Count up while running, restart at zero otherwise or after expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run_i && !expire_o) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);  // R4
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_i) |-> cnt_q == '0);  // R4

endmodule

// File: rtl/rcg_rst_pulse.sv
// Module: rcg_rst_pulse
// Stretches a one-cycle fire request into a receiver reset of RST_CYCLES.
// Assumes: fire_i never arrives while a pulse is still running.
module rcg_rst_pulse #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic pulse_o
);
    generate
        if (RST_CYCLES <= 1) begin : g_single
            logic hit_q;
            // Single-cycle pulse: one flop is enough.
            always_ff @(posedge clk) begin
                if (!rst_n) hit_q <= 1'b0;
                else        hit_q <= fire_i;
            end
            assign pulse_o = hit_q;
        end else begin : g_counted
            localparam int LEN_W = $clog2(RST_CYCLES + 1);
            localparam logic [LEN_W-1:0] LEN = LEN_W'(RST_CYCLES);
            logic [LEN_W-1:0] left_q;
            // Load the length on fire, count down to zero.
            always_ff @(posedge clk) begin
                if (!rst_n)              left_q <= '0;
                else if (fire_i)         left_q <= LEN;
                else if (left_q != '0)   left_q <= left_q - 1'b1;
            end
            assign pulse_o = (left_q != '0);

            AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
                fire_i |-> left_q == '0);  // R6
            AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                left_q <= LEN);  // R6
        end
    endgenerate

endmodule

// File: rtl/rcg_seq_fsm.sv
// Module: rcg_seq_fsm
// Sequencer for bring-up, promotion, low-power entry and wake. It decides
// the stuck check at the end of each dwell and asks for a reset pulse.
// Assumes: inputs are synchronous to clk; the dwell timer flags expiry.
module rcg_seq_fsm
    import rcg_pkg::*;
#(
    parameter int          CODE_W      = 6,
    parameter logic [CODE_W-1:0] ACTIVE_CODE = 6'h11,
    parameter logic [CODE_W-1:0] RLOCK_CODE  = 6'h0D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] train_code_i,
    input  logic              rx_valid_i,
    input  logic              partner_fast_i,
    input  logic              bringup_req_i,
    input  logic              sleep_req_i,
    input  logic              wake_req_i,
    input  logic              expire_i,
    output logic              dwell_o,
    output logic              fire_o,
    output logic              train_en_o,
    output logic              fast_allow_o,
    output logic              fast_req_o,
    output logic              low_power_o
);
    seq_state_t state_q, state_d;
    logic       fast_q;
    logic       active_seen;
    logic       stuck_now;

    assign active_seen = (train_code_i == ACTIVE_CODE);
    assign stuck_now   = (train_code_i == RLOCK_CODE) && !rx_valid_i;

    // Next-state selection for the whole sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (bringup_req_i) state_d = ST_QUIESCE;
            ST_QUIESCE:  state_d = ST_TRAIN;
            ST_TRAIN:    if (active_seen)
                             state_d = partner_fast_i ? ST_PROMOTE : ST_RUN;
            ST_PROMOTE:  state_d = ST_DWELL_UP;
            ST_DWELL_UP: if (expire_i) state_d = ST_RUN;
            ST_RUN:      if (sleep_req_i) state_d = ST_DWELL_DN;
            ST_DWELL_DN: if (expire_i) state_d = ST_SLEEP;
            ST_SLEEP:    if (wake_req_i) state_d = ST_WAKE;
            ST_WAKE:     state_d = ST_TRAIN;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // High-rate support: cleared on bring-up and wake, set on promotion.
    always_ff @(posedge clk) begin
        if (!rst_n)                                              fast_q <= 1'b0;
        else if (state_d == ST_QUIESCE || state_d == ST_WAKE)    fast_q <= 1'b0;
        else if (state_d == ST_PROMOTE)                          fast_q <= 1'b1;
    end

    assign dwell_o      = is_dwell(state_q);
    assign fire_o       = dwell_o && expire_i && stuck_now;
    assign train_en_o   = (state_q != ST_IDLE) && (state_q != ST_QUIESCE);
    assign fast_allow_o = fast_q;
    assign fast_req_o   = (state_q == ST_PROMOTE);
    assign low_power_o  = (state_q == ST_DWELL_DN) || (state_q == ST_SLEEP);

    AST_RELEASE_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_en_o) |-> !fast_allow_o);  // R2
    AST_REQ_WITH_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fast_req_o |-> fast_allow_o);  // R3
    AST_REQ_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fast_req_o) |-> $past(train_code_i == ACTIVE_CODE && partner_fast_i));  // R3
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fast_req_o |=> !fast_req_o);  // R3
    AST_WAKE_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE) |-> (!fast_allow_o && !low_power_o && train_en_o));  // R8
    AST_SLEEP_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_power_o) |-> $past(sleep_req_i));  // R7

endmodule

// File: rtl/rate_change_guard.sv
// Module: rate_change_guard (top)
// Wraps the sequencer, the dwell timer and the receiver reset stretcher.
// Assumes: CHECK_CYCLES is well above RST_CYCLES, so a pulse ends before
// the next check can be reached.
module rate_change_guard #(
    parameter int          CODE_W       = 6,
    parameter logic [CODE_W-1:0] ACTIVE_CODE  = 6'h11,
    parameter logic [CODE_W-1:0] RLOCK_CODE   = 6'h0D,
    parameter int          CHECK_CYCLES = 250000,
    parameter int          RST_CYCLES   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] train_code_i,
    input  logic              rx_valid_i,
    input  logic              partner_fast_i,
    input  logic              bringup_req_i,
    input  logic              sleep_req_i,
    input  logic              wake_req_i,
    output logic              train_en_o,
    output logic              fast_allow_o,
    output logic              fast_req_o,
    output logic              low_power_o,
    output logic              rx_rst_o
);
    logic dwell;
    logic expire;
    logic fire;

    rcg_seq_fsm #(
        .CODE_W      (CODE_W),
        .ACTIVE_CODE (ACTIVE_CODE),
        .RLOCK_CODE  (RLOCK_CODE)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .train_code_i   (train_code_i),
        .rx_valid_i     (rx_valid_i),
        .partner_fast_i (partner_fast_i),
        .bringup_req_i  (bringup_req_i),
        .sleep_req_i    (sleep_req_i),
        .wake_req_i     (wake_req_i),
        .expire_i       (expire),
        .dwell_o        (dwell),
        .fire_o         (fire),
        .train_en_o     (train_en_o),
        .fast_allow_o   (fast_allow_o),
        .fast_req_o     (fast_req_o),
        .low_power_o    (low_power_o)
    );

    rcg_dwell_timer #(
        .CHECK_CYCLES (CHECK_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (dwell),
        .expire_o (expire)
    );

    rcg_rst_pulse #(
        .RST_CYCLES (RST_CYCLES)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .pulse_o (rx_rst_o)
    );

    AST_RST_ON_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_rst_o) |-> $past(train_code_i == RLOCK_CODE && !rx_valid_i));  // R5
    AST_RST_AFTER_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_rst_o) |-> $past(dwell && expire));  // R4

endmodule

// File: tb/rate_change_guard_tb.sv
module rate_change_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 20;
    localparam int RST = 4;
    localparam logic [5:0] ACT   = 6'h11;
    localparam logic [5:0] RLOCK = 6'h0D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] code = 6'h00;
    logic valid = 1'b1, partner = 1'b1, bringup = 1'b0, sleep = 1'b0, wake = 1'b0;
    logic train_en, fast_allow, fast_req, low_power, rx_rst;
    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rate_change_guard #(
        .CODE_W(6), .ACTIVE_CODE(ACT), .RLOCK_CODE(RLOCK),
        .CHECK_CYCLES(N), .RST_CYCLES(RST)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .train_code_i(code), .rx_valid_i(valid),
        .partner_fast_i(partner), .bringup_req_i(bringup), .sleep_req_i(sleep),
        .wake_req_i(wake), .train_en_o(train_en), .fast_allow_o(fast_allow),
        .fast_req_o(fast_req), .low_power_o(low_power), .rx_rst_o(rx_rst)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One dwell window: cycle 0 is the current observed cycle; the dwell
    // ends at cycle L = base+N-1, where the end pattern is sampled.
    task automatic window(string req, int base, bit stuck_before,
                          logic [5:0] end_code, logic end_valid);
        int  last = base + N - 1;
        bit  end_stuck = (end_code == RLOCK) && !end_valid;
        for (int i = 0; i <= last + RST + 3; i++) begin
            check(req, int'(rx_rst), int'(end_stuck && i >= last + 1 && i <= last + RST));
            if (i == 0) begin
                code  = stuck_before ? RLOCK : ACT;
                valid = !stuck_before;
            end
            if (i == last) begin
                code  = end_code;
                valid = end_valid;
            end
            if (i == last + 1) begin
                code  = ACT;
                valid = 1'b1;
            end
            tick();
        end
    endtask

    task automatic promote(string req);
        code = ACT; partner = 1'b1;
        tick();
        check({req, " fast_req"}, int'(fast_req), 1);
        check({req, " fast_allow"}, int'(fast_allow), 1);
    endtask

    task automatic enter_sleep();
        sleep = 1'b1;
        tick();
        sleep = 1'b0;
        check("R7 low_power on entry", int'(low_power), 1);
    endtask

    task automatic do_wake();
        code = 6'h00;
        wake = 1'b1;
        tick();
        wake = 1'b0;
        check("R8 low_power cleared", int'(low_power), 0);
        check("R8 fast_allow cleared", int'(fast_allow), 0);
        check("R8 training kept on", int'(train_en), 1);
        tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 train_en", int'(train_en), 0);
        check("R1 fast_allow", int'(fast_allow), 0);
        check("R1 fast_req", int'(fast_req), 0);
        check("R1 low_power", int'(low_power), 0);
        check("R1 rx_rst", int'(rx_rst), 0);

        // R2 bring-up order
        bringup = 1'b1;
        tick();
        bringup = 1'b0;
        check("R2 training held off", int'(train_en), 0);
        check("R2 fast off in quiesce", int'(fast_allow), 0);
        tick();
        check("R2 training released", int'(train_en), 1);
        check("R2 fast still off", int'(fast_allow), 0);

        // R9 sleep ignored, R3 no request while not active
        sleep = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R9 sleep ignored in training", int'(low_power), 0);
            check("R3 no request before active", int'(fast_req), 0);
        end
        sleep = 1'b0;

        // R3/R4/R5 clean promotion
        promote("R3");
        window("R5 clean promotion", 1, 1'b0, ACT, 1'b1);

        // R9 wake and bring-up ignored while running
        wake = 1'b1; bringup = 1'b1;
        tick();
        wake = 1'b0; bringup = 1'b0;
        check("R9 wake ignored low_power", int'(low_power), 0);
        check("R9 wake ignored fast_allow", int'(fast_allow), 1);
        check("R9 bringup ignored train_en", int'(train_en), 1);

        // R7/R6 stuck low-power entry
        enter_sleep();
        window("R6 stuck sleep entry", 0, 1'b1, RLOCK, 1'b0);
        check("R7 low_power held", int'(low_power), 1);

        // R8 wake and re-promote; R5 stuck earlier but recovered at edge
        do_wake();
        promote("R8 repromotion");
        window("R5 recovered before sample", 1, 1'b1, RLOCK, 1'b1);

        // R4/R6 clean dwell, stuck only at sampling edge
        enter_sleep();
        window("R4 stuck at last cycle", 0, 1'b0, RLOCK, 1'b0);

        // R5 other code with valid low
        do_wake();
        promote("R8 repromotion");
        window("R5 other code valid low", 1, 1'b0, 6'h05, 1'b0);

        // R3 partner without fast support
        enter_sleep();
        window("R7 clean sleep entry", 0, 1'b0, ACT, 1'b1);
        do_wake();
        partner = 1'b0; code = ACT;
        for (int k = 0; k < 8; k++) begin
            tick();
            check("R3 slow partner no request", int'(fast_req), 0);
            check("R3 slow partner fast off", int'(fast_allow), 0);
        end
        // R7 reachable from slow running state
        enter_sleep();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule